// File: doc/BRIEF.md
# Bit-Band Alias Translator

This unit sits between one bus master and one memory or peripheral slave. Two 32 MB alias windows are decoded from the master address. Each 32-bit word in a window stands for a single bit of a smaller target region lower in the address map. A read of an alias word returns that target bit as 0 or 1. A write sets or clears that one bit through a locked read-modify-write on the slave port. Accesses outside both windows go through to the slave unchanged.

Both ports use one request handshake. The requester holds `valid` and the request fields steady. The responder raises `ready` for exactly one cycle to complete the transfer, and read data and error are valid in that cycle. Access size is coded 0 = byte, 1 = halfword, 2 = word, and 3 is treated as word. Sub-word data is right-aligned on both ports. Alias windows start at 0x22000000 and 0x42000000 and map onto target regions based at 0x20000000 and 0x40000000. All four bases are parameters.

Top module: `bitband_xlate`

## Requirements
- R1: While reset is held and after it is released, `m_ready`, `s_valid` and `s_lock` are low until a request arrives.
- R2: For a byte access to an alias window, the slave address is the target base ORed with alias offset bits [24:5], and the selected bit is offset bits [4:2].
- R3: For a halfword access, the slave address is the byte target address with bit 0 cleared, and the selected bit is offset bits [5:2].
- R4: For a word access, the slave address is the byte target address with bits [1:0] cleared, and the selected bit is offset bits [6:2].
- R5: An alias read makes one slave read of the same size and returns the selected bit in `m_rdata[0]`, with `m_rdata[31:1]` zero.
- R6: An alias write reads the target at the request size, then writes it back at that size. Only the selected bit changes. `m_wdata[0]` = 1 sets it and 0 clears it. All other bits of `m_wdata` are ignored.
- R7: Both slave phases of an alias access carry `s_lock` high. The write phase is presented in the cycle right after the read phase completes.
- R8: `m_ready` stays low from acceptance until the last slave phase has completed, then is high for exactly one cycle.
- R9: An access outside both windows reaches the slave with the same address, size, direction and write data, with `s_lock` low. Its read data returns unchanged, after one register stage.
- R10: A slave error in any phase of an access is reported on `m_err` when `m_ready` completes that access.
- R11: The second window maps 0x42000000-based alias words onto the 0x40000000-based target region by the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 1 | Master request valid |
| m_ready | output | 1 | Master request complete (one cycle) |
| m_write | input | 1 | Master request is a write |
| m_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data, right-aligned |
| m_rdata | output | 32 | Read data returned to master |
| m_err | output | 1 | Error returned to master |
| s_valid | output | 1 | Slave request valid |
| s_ready | input | 1 | Slave request complete |
| s_write | output | 1 | Slave request is a write |
| s_size | output | 2 | Slave access size |
| s_addr | output | 32 | Slave byte address |
| s_wdata | output | 32 | Slave write data, right-aligned |
| s_rdata | input | 32 | Slave read data, right-aligned |
| s_err | input | 1 | Slave error |
| s_lock | output | 1 | Locked read-modify-write in progress |

## Verification
On every cycle the assertions check four things: the one-cycle width of `m_ready`, that a locked write phase always follows a completed locked read phase directly, that a written-back word differs from the word read in at most one bit, and that alias reads return only bit 0. Address translation per access size, the choice between set and clear, window decoding for both regions, pass-through fidelity and error reporting depend on memory contents and address patterns. Only the bench scenarios against its slave model can show those.

// File: rtl/bitband_xlate.sv
module bitband_xlate #(
  parameter logic [31:0] ALIAS0_BASE  = 32'h2200_0000,
  parameter logic [31:0] TARGET0_BASE = 32'h2000_0000,
  parameter logic [31:0] ALIAS1_BASE  = 32'h4200_0000,
  parameter logic [31:0] TARGET1_BASE = 32'h4000_0000,
  parameter int          WIN_BITS     = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        m_valid,
  output logic        m_ready,
  input  logic        m_write,
  input  logic [1:0]  m_size,
  input  logic [31:0] m_addr,
  input  logic [31:0] m_wdata,
  output logic [31:0] m_rdata,
  output logic        m_err,
  output logic        s_valid,
  input  logic        s_ready,
  output logic        s_write,
  output logic [1:0]  s_size,
  output logic [31:0] s_addr,
  output logic [31:0] s_wdata,
  input  logic [31:0] s_rdata,
  input  logic        s_err,
  output logic        s_lock
);
  localparam int TOP = 32 - WIN_BITS;

  typedef enum logic [2:0] {IDLE, PASS, BB_RD, BB_WR, DONE} st_t;
  st_t st;

  logic        q_write, q_set, q_bb;
  logic [1:0]  q_size;
  logic [31:0] q_addr, q_wdata, rd_q;
  logic [4:0]  q_bit;

  logic [WIN_BITS-1:0] off;
  logic        hit0, hit1, hit;
  logic [31:0] tgt_byte, tgt;
  logic [4:0]  bit_idx;
  logic [31:0] sz_mask, onehot, modified;

  assign off  = m_addr[WIN_BITS-1:0];
  assign hit0 = m_addr[31:WIN_BITS] == ALIAS0_BASE[31:WIN_BITS];
  assign hit1 = m_addr[31:WIN_BITS] == ALIAS1_BASE[31:WIN_BITS];
  assign hit  = hit0 | hit1;

  assign tgt_byte = (hit0 ? TARGET0_BASE : TARGET1_BASE)
                  | {{(TOP + 5){1'b0}}, off[WIN_BITS-1:5]};

  always_comb begin
    case (m_size)
      2'd0:    begin tgt = tgt_byte;                  bit_idx = {2'b00, off[4:2]}; end
      2'd1:    begin tgt = {tgt_byte[31:1], 1'b0};    bit_idx = {1'b0, off[5:2]};  end
      default: begin tgt = {tgt_byte[31:2], 2'b00};   bit_idx = off[6:2];          end
    endcase
  end

  assign sz_mask  = (q_size == 2'd0) ? 32'h0000_00FF :
                    (q_size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign onehot   = 32'd1 << q_bit;
  assign modified = (q_set ? (s_rdata | onehot) : (s_rdata & ~onehot)) & sz_mask;

  assign s_valid = (st == PASS) || (st == BB_RD) || (st == BB_WR);
  assign s_lock  = (st == BB_RD) || (st == BB_WR);
  assign s_write = (st == PASS) ? q_write : (st == BB_WR);
  assign s_addr  = q_addr;
  assign s_size  = q_size;
  assign s_wdata = q_wdata;
  assign m_ready = (st == DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      q_write <= 1'b0;
      q_set   <= 1'b0;
      q_bb    <= 1'b0;
      q_size  <= 2'd0;
      q_addr  <= '0;
      q_wdata <= '0;
      q_bit   <= '0;
      rd_q    <= '0;
      m_rdata <= '0;
      m_err   <= 1'b0;
    end else begin
      case (st)
        IDLE: if (m_valid) begin
          q_write <= m_write;
          q_size  <= m_size;
          q_set   <= m_wdata[0];
          q_bb    <= hit;
          q_bit   <= bit_idx;
          q_addr  <= hit ? tgt : m_addr;
          q_wdata <= m_wdata;
          m_err   <= 1'b0;
          st      <= hit ? BB_RD : PASS;
        end
        PASS: if (s_ready) begin
          m_rdata <= s_rdata;
          m_err   <= s_err;
          st      <= DONE;
        end
        BB_RD: if (s_ready) begin
          m_rdata <= {31'd0, s_rdata[q_bit]};
          m_err   <= s_err;
          rd_q    <= s_rdata & sz_mask;
          q_wdata <= modified;
          st      <= q_write ? BB_WR : DONE;
        end
        BB_WR: if (s_ready) begin
          m_err <= m_err | s_err;
          st    <= DONE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R8
  one_cycle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready |=> !m_ready);

  // R7
  rmw_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_valid && s_write && s_lock) |-> $past(s_valid && s_lock && !s_write && s_ready));

  // R6
  one_bit_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_write && s_lock) |-> ($countones(s_wdata ^ rd_q) <= 1));

  // R5
  bit_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ready && q_bb && !q_write) |-> (m_rdata[31:1] == 31'd0));

  // R9
  held_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> (s_valid && $stable(s_addr) && $stable(s_write) && $stable(s_size)));
endmodule

// File: tb/bitband_xlate_tb.sv
`timescale 1ns/1ps
module bitband_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_valid = 1'b0, m_write = 1'b0;
  logic [1:0]  m_size = 2'd0;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic        m_ready, m_err;
  logic [31:0] m_rdata;
  logic        s_valid, s_write, s_lock;
  logic        s_ready, s_err;
  logic [1:0]  s_size;
  logic [31:0] s_addr, s_wdata, s_rdata;
  logic        err_inj = 1'b0;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  bitband_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_size(m_size),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_err(m_err),
    .s_valid(s_valid), .s_ready(s_ready), .s_write(s_write), .s_size(s_size),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata), .s_err(s_err),
    .s_lock(s_lock)
  );

  // slave model: 16 words, low address bits only; one wait cycle per phase
  logic [31:0] mem [16];
  logic [31:0] word_rd;
  assign word_rd = mem[s_addr[5:2]];
  always_comb begin
    case (s_size)
      2'd0:    s_rdata = {24'd0, word_rd[8*s_addr[1:0] +: 8]};
      2'd1:    s_rdata = {16'd0, word_rd[16*s_addr[1] +: 16]};
      default: s_rdata = word_rd;
    endcase
  end
  assign s_err = s_ready & err_inj;

  always @(posedge clk) begin
    if (!rst_n) s_ready <= 1'b0;
    else begin
      s_ready <= s_valid && !s_ready;
      if (s_valid && s_ready && s_write) begin
        case (s_size)
          2'd0:    mem[s_addr[5:2]][8*s_addr[1:0] +: 8] <= s_wdata[7:0];
          2'd1:    mem[s_addr[5:2]][16*s_addr[1] +: 16] <= s_wdata[15:0];
          default: mem[s_addr[5:2]] <= s_wdata;
        endcase
      end
    end
  end

  // monitor, sampled at the falling edge
  int          n_hs, n_rdy;
  logic [31:0] last_sa;
  logic        lock_hi, lock_lo, size_bad, gap_bad, prev_lrd;
  always @(negedge clk) begin
    if (s_valid && s_ready) begin
      n_hs++;
      last_sa = s_addr;
      if (s_lock) lock_hi = 1'b1; else lock_lo = 1'b1;
      if (s_size != m_size) size_bad = 1'b1;
    end
    if (prev_lrd && m_write && !(s_valid && s_write && s_lock)) gap_bad = 1'b1;
    prev_lrd = s_valid && s_ready && s_lock && !s_write;
    if (m_ready) n_rdy++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] got_rd;
  logic        got_err;
  int          hs_at_rdy;

  task automatic do_op(input logic wr, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd);
    int t = 0;
    @(negedge clk);
    n_hs = 0; n_rdy = 0; lock_hi = 0; lock_lo = 0; size_bad = 0; gap_bad = 0; prev_lrd = 0;
    m_valid = 1'b1; m_write = wr; m_size = sz; m_addr = a; m_wdata = wd;
    do begin
      @(negedge clk);
      t++;
    end while (!m_ready && t < 100);
    if (t >= 100) chk(1'b0, "watchdog", 32'(t), 32'd100);
    got_rd = m_rdata; got_err = m_err; hs_at_rdy = n_hs;
    @(negedge clk);
    m_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic [31:0] exp_sa;
    logic [1:0]  exp_n;
    logic        exp_lock;
    logic [3:0]  req;
  } vec_t;

  // memory preset: word 1 = 80000001, all else 0; both regions share the model's low bits
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd2, 32'h2200_0080, 32'h0, 32'h1,         32'h2000_0004, 2'd1, 1'b1, 4'd4},  // R4 bit0
    '{1'b0, 2'd2, 32'h2200_00FC, 32'h0, 32'h1,         32'h2000_0004, 2'd1, 1'b1, 4'd4},  // R4 bit31
    '{1'b0, 2'd2, 32'h2200_0084, 32'h0, 32'h0,         32'h2000_0004, 2'd1, 1'b1, 4'd5},  // R5 zero bit
    '{1'b0, 2'd0, 32'h2200_00FC, 32'h0, 32'h1,         32'h2000_0007, 2'd1, 1'b1, 4'd2},  // R2 byte 7 bit7
    '{1'b0, 2'd1, 32'h2200_00FC, 32'h0, 32'h1,         32'h2000_0006, 2'd1, 1'b1, 4'd3},  // R3 half 6 bit15
    '{1'b1, 2'd2, 32'h2200_0110, 32'h1, 32'h0,         32'h2000_0008, 2'd2, 1'b1, 4'd6},  // R6 set
    '{1'b0, 2'd2, 32'h2200_0110, 32'h0, 32'h1,         32'h2000_0008, 2'd1, 1'b1, 4'd6},  // R6 readback
    '{1'b1, 2'd0, 32'h2200_0080, 32'h0, 32'h0,         32'h2000_0004, 2'd2, 1'b1, 4'd6},  // R6 byte clear
    '{1'b1, 2'd2, 32'h2200_00FC, 32'hFFFF_FFFE, 32'h0, 32'h2000_0004, 2'd2, 1'b1, 4'd6},  // R6 clear, upper wdata ignored
    '{1'b0, 2'd2, 32'h2000_0004, 32'h0, 32'h0,         32'h2000_0004, 2'd1, 1'b0, 4'd9},  // R9 pass read
    '{1'b0, 2'd2, 32'h4200_0110, 32'h0, 32'h1,         32'h4000_0008, 2'd1, 1'b1, 4'd11}, // R11
    '{1'b1, 2'd2, 32'h2000_000C, 32'hDEAD_BEEF, 32'h0, 32'h2000_000C, 2'd1, 1'b0, 4'd9},  // R9 pass write
    '{1'b1, 2'd1, 32'h2200_01E0, 32'h1, 32'h0,         32'h2000_000E, 2'd2, 1'b1, 4'd3},  // R3 half set bit8
    '{1'b0, 2'd2, 32'h2000_000C, 32'h0, 32'hDFAD_BEEF, 32'h2000_000C, 2'd1, 1'b0, 4'd9},  // R9 read after
    '{1'b0, 2'd0, 32'h2000_000F, 32'h0, 32'h0000_00DF, 32'h2000_000F, 2'd1, 1'b0, 4'd9}   // R9 byte lane
  };

  initial begin
    #800000;
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    mem[1] = 32'h8000_0001;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!m_ready && !s_valid && !s_lock, "R1", {29'd0, m_ready, s_valid, s_lock}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!m_ready && !s_valid && !s_lock, "R1", {29'd0, m_ready, s_valid, s_lock}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string r;
      r = $sformatf("R%0d vec%0d", VEC[i].req, i);
      do_op(VEC[i].wr, VEC[i].sz, VEC[i].addr, VEC[i].wd);
      if (!VEC[i].wr) chk(got_rd == VEC[i].exp_rd, r, got_rd, VEC[i].exp_rd);
      chk(last_sa == VEC[i].exp_sa, r, last_sa, VEC[i].exp_sa);
      // R8: all slave phases done before the single m_ready cycle
      chk(hs_at_rdy == int'(VEC[i].exp_n) && n_rdy == 1, "R8", 32'(hs_at_rdy), 32'(VEC[i].exp_n));
      // R7 lock on both phases / R9 no lock
      chk(VEC[i].exp_lock ? (lock_hi && !lock_lo) : (lock_lo && !lock_hi), "R7/R9 lock",
          {30'd0, lock_hi, lock_lo}, {31'd0, VEC[i].exp_lock});
      chk(!size_bad && !gap_bad, "R7 size/adjacency", {30'd0, size_bad, gap_bad}, 32'd0);
      chk(!got_err, "R10 no error", {31'd0, got_err}, 32'd0);
    end

    chk(mem[1] == 32'h0, "R6 word1", mem[1], 32'h0);
    chk(mem[2] == 32'h10, "R6 word2", mem[2], 32'h10);
    chk(mem[3] == 32'hDFAD_BEEF, "R3 word3", mem[3], 32'hDFAD_BEEF);

    // R10 error on pass-through and on alias read
    err_inj = 1'b1;
    do_op(1'b0, 2'd2, 32'h2000_0000, 32'h0);
    chk(got_err, "R10 pass", {31'd0, got_err}, 32'd1);
    do_op(1'b0, 2'd2, 32'h2200_0000, 32'h0);
    chk(got_err, "R10 alias", {31'd0, got_err}, 32'd1);
    do_op(1'b1, 2'd2, 32'h2200_0000, 32'h1);
    chk(got_err, "R10 rmw", {31'd0, got_err}, 32'd1);
    err_inj = 1'b0;
    do_op(1'b0, 2'd2, 32'h2000_0000, 32'h0);
    chk(!got_err && got_rd == 32'h1, "R10 clear", {got_rd[30:0], got_err}, 32'h2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule